// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable ratio of M·N + A. A dual-modulus prescaler counts either M or M+1 input cycles per prescaler cycle. A main counter loaded with N counts prescaler cycles. A swallow counter loaded with A holds the prescaler at M+1 until the swallow counter has run out. One output period therefore spans A prescaler cycles of M+1 clocks and N−A prescaler cycles of M clocks. This reaches every total ratio, not only multiples of M.

The base modulus M is 64 or 128. N is an 11-bit count and A is a 7-bit count. A new setting is accepted only at the boundary between two output periods, so a period never mixes old and new values. A setting with N below 3, or with A not below N, is rejected. The block raises a status flag for it and keeps running with the last accepted setting.

Top module: `swallow_divider`

## Requirements
- R1: With an accepted setting, `div_pulse` is high for one cycle once every M·N + A clock cycles.
- R2: `mod_sel` = 0 selects M = 64 and `mod_sel` = 1 selects M = 128.
- R3: The prescaler runs at M+1 for the first A prescaler cycles of a period and at M for the rest. This holds at both limits of the swallow count, A = 0 and A = N−1.
- R4: A change to `mod_sel`, `n_val` or `a_val` during a period does not alter the length of that period. The inputs are sampled at the clock edge on which `div_pulse` rises, and that sample sets the next period.
- R5: A setting with `n_val` < 3 or `a_val` ≥ `n_val` is illegal. One clock edge after such inputs are applied, `cfg_err` reads 1. The periods that follow use the last accepted setting.
- R6: While `rst` is high, `div_pulse` and `cfg_err` are 0. The first period starts at the last reset edge and uses the inputs present there. If those inputs are illegal, it uses M = 64, N = 3, A = 0, a ratio of 192. The first pulse is visible after the edge that comes M·N + A edges after the last reset edge.
- R7: One clock edge after legal inputs return, `cfg_err` reads 0.
- R8: `div_pulse` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_sel | input | 1 | Base modulus select: 0 for 64, 1 for 128 |
| n_val | input | 11 | Main count N |
| a_val | input | 7 | Swallow count A |
| div_pulse | output | 1 | One-cycle pulse per output period |
| cfg_err | output | 1 | Illegal setting flag, registered |

## Verification
A wrong prescaler reload value, or a swallow count that runs one cycle too long or too short, shows up as an output period that is off by a few clocks. The error appears at the very next `div_pulse`, so the bench measures every interval between pulses exactly against M·N + A. A setting that leaks in mid-period changes the length of the period that is already running, and that wrong interval is seen one pulse later. A rejected setting that is wrongly accepted alters the following period, and an illegal-input flag that comes late or not at all is caught one edge after the inputs change.

// File: rtl/swd_pkg.sv
package swd_pkg;
    parameter int N_W   = 11;
    parameter int A_W   = 7;
    parameter int M_LO  = 64;
    parameter int M_HI  = 128;
    parameter int N_MIN = 3;
    localparam int PC_W = $clog2(M_HI + 1);

    typedef struct packed {
        logic           wide;
        logic [N_W-1:0] n;
        logic [A_W-1:0] a;
    } div_cfg_t;

    localparam div_cfg_t CFG_DEFAULT = '{wide: 1'b0, n: N_W'(N_MIN), a: '0};

    function automatic logic cfg_ok(div_cfg_t c);
        return (c.n >= N_W'(N_MIN)) && (N_W'(c.a) < c.n);
    endfunction

    // Reload value of the prescaler down-counter: a cycle lasts limit+1 clocks
    function automatic logic [PC_W-1:0] pre_limit(logic wide, logic ext);
        logic [PC_W-1:0] base;
        base = wide ? PC_W'(M_HI) : PC_W'(M_LO);
        return ext ? base : base - 1'b1;
    endfunction
endpackage

// File: rtl/swd_cfg_gate.sv
module swd_cfg_gate
    import swd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  div_cfg_t req_cfg,
    output div_cfg_t load_cfg,
    output div_cfg_t held_cfg,
    output logic     cfg_err
);
    div_cfg_t held_q;
    logic     req_ok;

    always_comb begin
        req_ok   = cfg_ok(req_cfg);
        load_cfg = req_ok ? req_cfg : (rst ? CFG_DEFAULT : held_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= load_cfg;
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= !req_ok;
            if (load) held_q <= load_cfg;
        end
    end

    assign held_cfg = held_q;

    AST_HELD_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cfg_ok(held_q)); // R5
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(held_q)); // R4
endmodule

// File: rtl/swd_prescaler.sv
module swd_prescaler
    import swd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wide_nxt,
    input  logic            ext_nxt,
    input  logic            wide_run,
    output logic            tick,
    output logic [PC_W-1:0] pc
);
    logic [PC_W-1:0] pc_q;

    assign tick = (pc_q == '0);
    assign pc   = pc_q;

    always_ff @(posedge clk) begin
        if (rst || tick) pc_q <= pre_limit(wide_nxt, ext_nxt);
        else             pc_q <= pc_q - 1'b1;
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
        pc_q <= pre_limit(wide_run, 1'b1)); // R2
endmodule

// File: rtl/swd_cycle_ctrl.sv
module swd_cycle_ctrl
    import swd_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  div_cfg_t       load_cfg,
    output logic           boundary,
    output logic           ext_nxt,
    output logic           div_pulse,
    output logic [N_W-1:0] nc,
    output logic [A_W-1:0] ac
);
    logic [N_W-1:0] nc_q;
    logic [A_W-1:0] ac_q;

    always_comb begin
        boundary = tick && (nc_q == N_W'(1));
        if (rst || boundary) ext_nxt = (load_cfg.a != '0);
        else                 ext_nxt = (ac_q > A_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || boundary) begin
            nc_q <= load_cfg.n;
            ac_q <= load_cfg.a;
        end else if (tick) begin
            nc_q <= nc_q - 1'b1;
            if (ac_q != '0) ac_q <= ac_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) div_pulse <= 1'b0;
        else     div_pulse <= boundary;
    end

    assign nc = nc_q;
    assign ac = ac_q;

    AST_SWALLOW_BELOW_MAIN: assert property (@(posedge clk) disable iff (rst)
        N_W'(ac_q) < nc_q); // R3
    AST_MAIN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        nc_q != '0); // R1
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse); // R8
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
    import swd_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           mod_sel,
    input  logic [N_W-1:0] n_val,
    input  logic [A_W-1:0] a_val,
    output logic           div_pulse,
    output logic           cfg_err
);
    div_cfg_t        req_cfg, load_cfg, held_cfg;
    logic            boundary, ext_nxt, tick, wide_nxt;
    logic [PC_W-1:0] pc;
    logic [N_W-1:0]  nc;
    logic [A_W-1:0]  ac;

    assign req_cfg  = '{wide: mod_sel, n: n_val, a: a_val};
    assign wide_nxt = (rst || boundary) ? load_cfg.wide : held_cfg.wide;

    swd_cfg_gate u_gate (
        .clk(clk), .rst(rst), .load(boundary), .req_cfg(req_cfg),
        .load_cfg(load_cfg), .held_cfg(held_cfg), .cfg_err(cfg_err)
    );

    swd_prescaler u_pre (
        .clk(clk), .rst(rst), .wide_nxt(wide_nxt), .ext_nxt(ext_nxt),
        .wide_run(held_cfg.wide), .tick(tick), .pc(pc)
    );

    swd_cycle_ctrl u_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .load_cfg(load_cfg),
        .boundary(boundary), .ext_nxt(ext_nxt), .div_pulse(div_pulse),
        .nc(nc), .ac(ac)
    );

    AST_RELOAD_MATCH: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> (nc == held_cfg.n) && (ac == held_cfg.a) &&
                      (pc == pre_limit(held_cfg.wide, held_cfg.a != '0))); // R1
endmodule

// File: tb/tb_swallow_divider.sv
module tb_swallow_divider;
    import swd_pkg::*;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           mod_sel = 1'b0;
    logic [N_W-1:0] n_val = N_W'(1);
    logic [A_W-1:0] a_val = '0;
    logic           div_pulse, cfg_err;

    int    checks = 0, errors = 0;
    int    pulses_seen = 0, pushed = 0, cyc_cnt = 0;
    int    exp_q[$];
    string tag_q[$];
    bit    done = 1'b0, last_pulse = 1'b0;
    bit    held_w;
    int    held_n, held_a;

    swallow_divider dut (
        .clk(clk), .rst(rst), .mod_sel(mod_sel), .n_val(n_val),
        .a_val(a_val), .div_pulse(div_pulse), .cfg_err(cfg_err)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_exp(input string tag);
        exp_q.push_back((held_w ? M_HI : M_LO) * held_n + held_a);
        tag_q.push_back(tag);
        pushed++;
    endtask

    // Monitor: measures every interval between pulses against the scoreboard
    always @(posedge clk) begin
        int    e;
        string t;
        #1;
        if (rst) begin
            cyc_cnt    = 0;
            last_pulse = 1'b0;
        end else begin
            cyc_cnt++;
            if (last_pulse) chk(!div_pulse, "R8 pulse width", div_pulse, 0);
            last_pulse = div_pulse;
            if (div_pulse) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected pulse", cyc_cnt, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(cyc_cnt == e, {t, " period length"}, cyc_cnt, e);
                end
                pulses_seen++;
                cyc_cnt = 0;
            end
        end
    end

    // Driver: a new setting applies to the period after the running one (R4)
    task automatic apply(input bit w, input int n, input int a, input string tag);
        bit legal;
        while (pulses_seen < pushed - 1) @(negedge clk);
        @(negedge clk);
        mod_sel = w;
        n_val   = N_W'(n);
        a_val   = A_W'(a);
        legal   = (n >= 3) && (a < n);
        if (legal) begin
            held_w = w; held_n = n; held_a = a;
        end
        push_exp(tag);
        @(posedge clk);
        #1;
        chk(cfg_err == !legal, legal ? "R7 cfg_err clear" : "R5 cfg_err set",
            cfg_err, !legal);
    endtask

    initial begin
        held_w = 1'b0; held_n = 3; held_a = 0;
        push_exp("R6");   // illegal inputs during reset: default ratio 192
        repeat (3) @(negedge clk);
        @(posedge clk); #1;
        chk(div_pulse == 1'b0, "R6 pulse in reset", div_pulse, 0);
        chk(cfg_err == 1'b0, "R6 cfg_err in reset", cfg_err, 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(cfg_err == 1'b1, "R5 cfg_err after reset", cfg_err, 1);

        apply(1'b0, 4, 2, "R1");      // 258
        apply(1'b1, 3, 1, "R2");      // 385
        apply(1'b0, 5, 4, "R3");      // 324, A = N-1
        apply(1'b1, 3, 0, "R3");      // 384, A = 0
        apply(1'b0, 4, 4, "R5");      // A = N: keeps 384
        apply(1'b0, 2, 0, "R5");      // N < 3: keeps 384
        apply(1'b0, 6, 3, "R7");      // 387
        apply(1'b0, 300, 127, "R1");  // 19327
        apply(1'b0, 7, 6, "R4");      // 454, set mid-period of the long one
        apply(1'b1, 3, 2, "R4");      // 386

        while (pulses_seen < pushed) @(negedge clk);
        chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R1 watchdog expired", pulses_seen, pushed);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule